// File: doc/BRIEF.md
# Pipelined SRAM Slave with Cycle Countdown

This block connects a simple on-chip master to a 32-bit asynchronous SRAM. The master raises a one-cycle read or write strobe together with an address and, for writes, the data word. The slave captures these in the same clock edge, so the master may change them in the next cycle. It then runs the SRAM chip-select, output-enable, write-enable, address and data pins through a fixed access sequence. For reads it captures the returned word into an output register.

The slave has no single acknowledge. Instead it drives a small countdown that always says how many clock cycles remain until the oldest outstanding transfer finishes. The countdown reads zero in the cycle where read data is valid, or where a write has finished. A constant pipeline-level output tells the master how early it may overlap its next command. At level 0 the master waits until the slave is idle. At level 1 it may issue in the cycle where the countdown shows zero. At level 2 it may issue one cycle before that. A master doing a cache-line fill at level 2 can therefore issue back-to-back reads every two cycles.

A command that arrives outside that window is dropped, and a sticky error flag is raised. A cycle with both strobes high is treated the same way.

Top module: `sram_pipe_slave`

## Requirements
- R1: The address and write data are captured at the edge that ends the command cycle. The SRAM address and data pins keep these values for the whole access, whatever the master drives on its command inputs afterwards.
- R2: After an accepted read, `cnt_left` shows WAIT_ST+1 in the next cycle and then falls by one each cycle. `rd_data` holds the word read from the SRAM in the cycle where `cnt_left` reaches 0 (cycle C+WAIT_ST+2 for a command in cycle C).
- R3: After an accepted write, `cnt_left` shows WAIT_ST+2 in the next cycle and then falls by one each cycle. It reaches 0 in the first cycle after the SRAM write sequence has ended.
- R4: `cnt_left` is 0 whenever no transfer is outstanding, and it never wraps below 0.
- R5: `pipe_lvl` always equals the PIPE_LVL parameter (supported values 0, 1 and 2).
- R6: A command is accepted when either condition holds:
  - no transfer is outstanding; or
  - no second transfer is queued and `cnt_left` is below PIPE_LVL.
  At level 0, a command in the zero cycle of the previous transfer is refused. At level 1 such a command is accepted.
- R7: While two transfers overlap, `cnt_left` follows the older one down to 0. In the following cycle it shows the remaining count of the newer one.
- R8: A refused command, or a cycle with both `cmd_rd` and `cmd_wr` high, causes no SRAM activity and leaves the memory unchanged. It sets `proto_err` from the next cycle on, and only reset clears `proto_err`.
- R9: A read access holds `sram_ce_n` and `sram_oe_n` low for WAIT_ST+1 cycles, starting in the cycle after the command. During the read access `sram_we_n` stays high and `sram_dq_oe` stays low.
- R10: A write access holds `sram_ce_n` low and `sram_dq_oe` high for WAIT_ST+2 cycles. `sram_we_n` is low only in the WAIT_ST middle cycles of the write. Address and data stay stable in the cycle before write-enable falls and in the cycle after it rises.
- R11: A read returns the last data written to that address, including a read issued in the earliest cycle the window allows after the write.
- R12: While reset is high, `cnt_left` is 0, `proto_err` is 0 and all SRAM strobes are inactive (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_rd | input | 1 | One-cycle read command strobe |
| cmd_wr | input | 1 | One-cycle write command strobe |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_wdata | input | DATA_W | Write data of the command |
| rd_data | output | DATA_W | Registered read result |
| cnt_left | output | CNT_W | Cycles until the oldest transfer completes |
| pipe_lvl | output | 2 | Advertised overlap level |
| proto_err | output | 1 | Sticky flag for a refused command |
| sram_addr | output | ADDR_W | SRAM address pins |
| sram_dq_out | output | DATA_W | Data driven towards the SRAM |
| sram_dq_in | input | DATA_W | Data returned by the SRAM |
| sram_dq_oe | output | 1 | High while the slave drives the data pins |
| sram_ce_n | output | 1 | SRAM chip select, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The properties assume that the command strobes are known values after reset, and that reset is held for at least two clock edges so that every register starts from a defined state. They put no limit on when the master may issue a command, because a command outside the window is refused by design. The stimulus issues most commands exactly at the earliest cycle that each lane's level allows. This exercises the window edges without crossing them. A few directed cases break the window on purpose, or raise both strobes, to exercise the refusal path. The SRAM model returns data combinationally whenever chip select and output enable are both low, and the read path relies on this.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } sps_op_e;

    // Countdown value loaded when a transfer of the given kind is accepted.
    function automatic int unsigned sps_load(input sps_op_e op, input int unsigned ws);
        return (op == OP_WR) ? ws + 2 : ws + 1;
    endfunction

    // Index of the final SRAM phase of an access.
    function automatic int unsigned sps_last_phase(input sps_op_e op, input int unsigned ws);
        return (op == OP_WR) ? ws + 1 : ws;
    endfunction

endpackage

// File: rtl/sps_cnt_track.sv
module sps_cnt_track
    import sps_pkg::*;
#(
    parameter int unsigned WAIT_ST  = 1,
    parameter int unsigned PIPE_LVL = 2,
    parameter int unsigned CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  sps_op_e          take_op,
    output logic             may_take,
    output logic [CNT_W-1:0] cnt_left
);
    localparam int unsigned NSLOT = 2;

    logic [NSLOT-1:0] vld_q, vld_d;
    logic [CNT_W-1:0] rem_q [NSLOT];
    logic [CNT_W-1:0] rem_d [NSLOT];
    logic [CNT_W-1:0] ld_val;
    logic             retire;

    function automatic logic [CNT_W-1:0] dec_sat(input logic [CNT_W-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    always_comb begin
        ld_val = CNT_W'(sps_load(take_op, WAIT_ST));
        retire = vld_q[0] && (rem_q[0] == '0);
        if (retire) begin
            vld_d    = {1'b0, vld_q[1]};
            rem_d[0] = dec_sat(rem_q[1]);
            rem_d[1] = '0;
        end else begin
            vld_d = vld_q;
            for (int k = 0; k < NSLOT; k++) begin
                rem_d[k] = dec_sat(rem_q[k]);
            end
        end
        if (take) begin
            if (!vld_d[0]) begin
                vld_d[0] = 1'b1;
                rem_d[0] = ld_val;
            end else begin
                vld_d[1] = 1'b1;
                rem_d[1] = ld_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int k = 0; k < NSLOT; k++) begin
                rem_q[k] <= '0;
            end
        end else begin
            vld_q <= vld_d;
            for (int k = 0; k < NSLOT; k++) begin
                rem_q[k] <= rem_d[k];
            end
        end
    end

    assign may_take = !vld_q[1] && (!vld_q[0] || (int'(rem_q[0]) < int'(PIPE_LVL)));
    assign cnt_left = vld_q[0] ? rem_q[0] : '0;

endmodule

// File: rtl/sps_sram_eng.sv
module sps_sram_eng
    import sps_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned WAIT_ST = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  sps_op_e           start_op,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);
    localparam int unsigned PH_W = $clog2(WAIT_ST + 2);

    logic              busy_q;
    sps_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [PH_W-1:0]   ph_q;
    logic [PH_W-1:0]   ph_last;
    logic              rd_last;

    assign ph_last = PH_W'(sps_last_phase(op_q, WAIT_ST));
    assign rd_last = busy_q && (op_q == OP_RD) && (ph_q == ph_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            op_q    <= OP_RD;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            ph_q    <= '0;
        end else begin
            if (rd_last) begin
                rdata_q <= sram_dq_in;
            end
            if (start) begin
                busy_q  <= 1'b1;
                op_q    <= start_op;
                addr_q  <= start_addr;
                wdata_q <= start_wdata;
                ph_q    <= '0;
            end else if (busy_q) begin
                if (ph_q == ph_last) begin
                    busy_q <= 1'b0;
                    ph_q   <= '0;
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end
        end
    end

    assign rd_data     = rdata_q;
    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;
    assign sram_dq_oe  = busy_q && (op_q == OP_WR);
    assign sram_ce_n   = !busy_q;
    assign sram_oe_n   = !(busy_q && (op_q == OP_RD));
    assign sram_we_n   = !(busy_q && (op_q == OP_WR) && (ph_q != '0) && (ph_q != ph_last));

endmodule

// File: rtl/sram_pipe_slave.sv
module sram_pipe_slave
    import sps_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned WAIT_ST  = 1,
    parameter int unsigned PIPE_LVL = 2,
    localparam int unsigned CNT_W   = $clog2(WAIT_ST + 3)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  cnt_left,
    output logic [1:0]        pipe_lvl,
    output logic              proto_err,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);
    logic    any_cmd;
    logic    dual_cmd;
    logic    may_take;
    logic    take;
    sps_op_e take_op;
    logic    err_q;

    assign any_cmd  = cmd_rd || cmd_wr;
    assign dual_cmd = cmd_rd && cmd_wr;
    assign take     = any_cmd && !dual_cmd && may_take;
    assign take_op  = cmd_wr ? OP_WR : OP_RD;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (any_cmd && !take) begin
            err_q <= 1'b1;
        end
    end

    sps_cnt_track #(
        .WAIT_ST (WAIT_ST),
        .PIPE_LVL(PIPE_LVL),
        .CNT_W   (CNT_W)
    ) track_i (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .take_op (take_op),
        .may_take(may_take),
        .cnt_left(cnt_left)
    );

    sps_sram_eng #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WAIT_ST(WAIT_ST)
    ) eng_i (
        .clk        (clk),
        .rst        (rst),
        .start      (take),
        .start_op   (take_op),
        .start_addr (cmd_addr),
        .start_wdata(cmd_wdata),
        .sram_dq_in (sram_dq_in),
        .rd_data    (rd_data),
        .sram_addr  (sram_addr),
        .sram_dq_out(sram_dq_out),
        .sram_dq_oe (sram_dq_oe),
        .sram_ce_n  (sram_ce_n),
        .sram_oe_n  (sram_oe_n),
        .sram_we_n  (sram_we_n)
    );

    assign pipe_lvl  = 2'(PIPE_LVL);
    assign proto_err = err_q;

endmodule

// File: rtl/sram_pipe_slave_chk.sv
module sram_pipe_slave_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_rd,
    input logic              cmd_wr,
    input logic [CNT_W-1:0]  cnt_left,
    input logic              proto_err,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              sram_dq_oe,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n
);
    // R2 / R7: a non-zero count always steps down by exactly one
    a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
        (cnt_left != '0) |=> (cnt_left == $past(cnt_left) - 1'b1));

    // R8: the error flag never clears outside reset
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    // R8: both strobes at once is always flagged
    a_r8_dual_strobe: assert property (@(posedge clk) disable iff (rst)
        (cmd_rd && cmd_wr) |=> proto_err);

    // R9: output enable only inside a selected read with the bus released
    a_r9_read_ctrl: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n && !sram_dq_oe));

    // R10: write enable only inside a selected write with data driven
    a_r10_we_ctrl: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n && sram_dq_oe));

    // R10: setup cycle before write enable falls
    a_r10_we_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_dq_out) && !$past(sram_ce_n)));

    // R10: hold cycle after write enable rises
    a_r10_we_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_dq_out) && !sram_ce_n && sram_dq_oe));

endmodule

bind sram_pipe_slave sram_pipe_slave_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_rd     (cmd_rd),
    .cmd_wr     (cmd_wr),
    .cnt_left   (cnt_left),
    .proto_err  (proto_err),
    .sram_addr  (sram_addr),
    .sram_dq_out(sram_dq_out),
    .sram_dq_oe (sram_dq_oe),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n)
);

// File: tb/sram_pipe_slave_tb_top.sv
module sram_pipe_slave_tb_top;
    localparam int unsigned AW = 6;
    localparam int unsigned DW = 32;
    localparam int unsigned WS = 1;
    localparam int unsigned NL = 3;
    localparam int NV = 12;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } vec_t;

    // reads ignore the data field
    localparam vec_t VEC [NV] = '{
        '{1'b1, 6'd0, 32'h1111_0000},
        '{1'b1, 6'd1, 32'h2222_0001},
        '{1'b0, 6'd0, 32'h0},
        '{1'b0, 6'd1, 32'h0},
        '{1'b1, 6'd2, 32'h3333_0002},
        '{1'b0, 6'd2, 32'h0},
        '{1'b0, 6'd0, 32'h0},
        '{1'b0, 6'd5, 32'h0},
        '{1'b1, 6'd0, 32'h4444_0000},
        '{1'b0, 6'd0, 32'h0},
        '{1'b0, 6'd1, 32'h0},
        '{1'b0, 6'd2, 32'h0}
    };

    logic clk = 1'b0;
    logic rst;
    always #2 clk = ~clk;

    int   n_chk = 0;
    int   n_err = 0;
    logic done  = 1'b0;

    logic          c_rd [NL];
    logic          c_wr [NL];
    logic [AW-1:0] c_addr [NL];
    logic [DW-1:0] c_wd [NL];
    logic [DW-1:0] o_rd [NL];
    logic [1:0]    o_cnt [NL];
    logic [1:0]    o_lvl [NL];
    logic          o_err [NL];
    logic [AW-1:0] s_addr [NL];
    logic [DW-1:0] s_dout [NL];
    logic [DW-1:0] s_din [NL];
    logic          s_doe [NL];
    logic          s_ce [NL];
    logic          s_oe [NL];
    logic          s_we [NL];
    logic [DW-1:0] exp_mem [NL][64];

    for (genvar lv = 0; lv < NL; lv++) begin : g_lane
        logic [DW-1:0] mem [64];
        initial for (int i = 0; i < 64; i++) mem[i] = '0;
        always @(posedge clk) if (!s_ce[lv] && !s_we[lv]) mem[s_addr[lv]] <= s_dout[lv];
        assign s_din[lv] = (!s_ce[lv] && !s_oe[lv]) ? mem[s_addr[lv]] : '0;

        sram_pipe_slave #(
            .ADDR_W(AW), .DATA_W(DW), .WAIT_ST(WS), .PIPE_LVL(lv)
        ) dut_i (
            .clk(clk), .rst(rst),
            .cmd_rd(c_rd[lv]), .cmd_wr(c_wr[lv]), .cmd_addr(c_addr[lv]), .cmd_wdata(c_wd[lv]),
            .rd_data(o_rd[lv]), .cnt_left(o_cnt[lv]), .pipe_lvl(o_lvl[lv]), .proto_err(o_err[lv]),
            .sram_addr(s_addr[lv]), .sram_dq_out(s_dout[lv]), .sram_dq_in(s_din[lv]),
            .sram_dq_oe(s_doe[lv]), .sram_ce_n(s_ce[lv]), .sram_oe_n(s_oe[lv]), .sram_we_n(s_we[lv])
        );
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic quiet();
        for (int l = 0; l < NL; l++) begin
            c_rd[l] = 1'b0; c_wr[l] = 1'b0; c_addr[l] = '1; c_wd[l] = 32'hBAD0_BAD0;
        end
    endtask

    task automatic drv(input int lv, input logic rd, input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        c_rd[lv] = rd; c_wr[lv] = wr; c_addr[lv] = a; c_wd[lv] = d;
    endtask

    // Walk the vector table on one lane, issuing each command at the earliest legal cycle.
    task automatic run_lane(input int lv);
        int            due_t [NV];
        logic          due_wr [NV];
        logic [DW-1:0] due_d [NV];
        int nxt = 0, i = 0, last = 0, n;
        for (int t = 0; t < 400; t++) begin
            tick();
            for (int k = 0; k < i; k++) begin
                if (due_t[k] == t) begin
                    chk(due_wr[k] ? "R3" : "R2", "count zero at completion", 32'(o_cnt[lv]), 0);
                    if (!due_wr[k]) chk("R11", "read data", o_rd[lv], due_d[k]);
                end
            end
            if (i < NV && t == nxt) begin
                n = VEC[i].wr ? int'(WS) + 2 : int'(WS) + 1;
                drv(lv, !VEC[i].wr, VEC[i].wr, VEC[i].a, VEC[i].d ^ DW'(lv));
                due_t[i]  = t + n + 1;
                due_wr[i] = VEC[i].wr;
                due_d[i]  = VEC[i].wr ? '0 : exp_mem[lv][VEC[i].a];
                if (VEC[i].wr) exp_mem[lv][VEC[i].a] = VEC[i].d ^ DW'(lv);
                nxt  = t + n + 2 - lv;
                last = due_t[i];
                i++;
            end else begin
                quiet();
            end
            if (i == NV && t > last) break;
        end
        chk("R6", "no error when issuing at window edge", 32'(o_err[lv]), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v7;
        for (int l = 0; l < NL; l++) for (int a = 0; a < 64; a++) exp_mem[l][a] = '0;
        rst = 1'b1;
        quiet();
        repeat (4) tick();
        // R12 / R5 / R4: reset state
        for (int l = 0; l < NL; l++) begin
            chk("R12", "cnt in reset", 32'(o_cnt[l]), 0);
            chk("R12", "err in reset", 32'(o_err[l]), 0);
            chk("R12", "strobes idle", {29'd0, s_ce[l], s_oe[l], s_we[l]}, 32'h7);
            chk("R5", "pipe level", 32'(o_lvl[l]), 32'(l));
        end
        rst = 1'b0;
        tick();
        chk("R4", "idle count", 32'(o_cnt[2]), 0);

        for (int l = 0; l < NL; l++) run_lane(l);

        // R1 / R2 / R9: read timing on lane 2
        repeat (2) tick();
        drv(2, 1'b1, 1'b0, 6'd1, '0);
        tick(); quiet();
        chk("R2", "read count first", 32'(o_cnt[2]), WS + 1);
        chk("R9", "read strobes ce/oe/we/doe", {28'd0, s_ce[2], s_oe[2], s_we[2], s_doe[2]}, 32'h2);
        chk("R1", "address captured", 32'(s_addr[2]), 1);
        tick();
        chk("R2", "read count second", 32'(o_cnt[2]), 1);
        chk("R1", "address held", 32'(s_addr[2]), 1);
        chk("R9", "oe still low", 32'(s_oe[2]), 0);
        tick();
        chk("R2", "read count zero", 32'(o_cnt[2]), 0);
        chk("R2", "read data", o_rd[2], exp_mem[2][1]);
        chk("R9", "read released", {30'd0, s_ce[2], s_oe[2]}, 32'h3);
        tick();
        chk("R4", "count saturates", 32'(o_cnt[2]), 0);

        // R3 / R10: write timing on lane 2
        v7 = 32'hA5A5_0007;
        drv(2, 1'b0, 1'b1, 6'd7, v7);
        tick(); quiet();
        chk("R3", "write count first", 32'(o_cnt[2]), WS + 2);
        chk("R10", "setup ce/we/doe", {29'd0, s_ce[2], s_we[2], s_doe[2]}, 32'h3);
        chk("R1", "write data captured", s_dout[2], v7);
        tick();
        chk("R3", "write count second", 32'(o_cnt[2]), 2);
        chk("R10", "we low in middle", 32'(s_we[2]), 0);
        tick();
        chk("R3", "write count third", 32'(o_cnt[2]), 1);
        chk("R10", "hold ce/we/doe", {29'd0, s_ce[2], s_we[2], s_doe[2]}, 32'h3);
        chk("R10", "hold address", 32'(s_addr[2]), 7);
        tick();
        chk("R3", "write done", 32'(o_cnt[2]), 0);
        chk("R10", "write released", {30'd0, s_ce[2], s_doe[2]}, 32'h2);
        exp_mem[2][7] = v7;

        // R8: refused write during read, lane 2
        drv(2, 1'b1, 1'b0, 6'd7, '0);
        tick();
        drv(2, 1'b0, 1'b1, 6'd7, 32'hDEAD_DEAD);
        chk("R8", "no error yet", 32'(o_err[2]), 0);
        tick(); quiet();
        chk("R8", "error raised", 32'(o_err[2]), 1);
        tick();
        chk("R11", "read after write", o_rd[2], v7);
        repeat (3) tick();
        drv(2, 1'b1, 1'b0, 6'd7, '0);
        tick(); quiet(); tick(); tick();
        chk("R8", "refused write had no effect", o_rd[2], v7);
        chk("R8", "error sticky", 32'(o_err[2]), 1);

        // R6: zero-cycle command, level 0 refuses, level 1 accepts
        tick();
        drv(0, 1'b1, 1'b0, 6'd3, '0);
        drv(1, 1'b1, 1'b0, 6'd3, '0);
        tick(); quiet(); tick(); tick();
        drv(0, 1'b1, 1'b0, 6'd4, '0);
        drv(1, 1'b1, 1'b0, 6'd4, '0);
        tick(); quiet();
        chk("R6", "level 0 refuses", 32'(o_err[0]), 1);
        chk("R6", "level 0 stays idle", {30'd0, s_ce[0], o_cnt[0] == 2'd0}, 32'h3);
        chk("R6", "level 1 accepts", 32'(o_err[1]), 0);
        chk("R6", "level 1 count loaded", 32'(o_cnt[1]), WS + 1);
        tick(); tick();
        chk("R6", "level 1 read data", o_rd[1], exp_mem[1][4]);

        // R8: both strobes on lane 1
        drv(1, 1'b1, 1'b1, 6'd5, 32'h5555_5555);
        tick(); quiet();
        chk("R8", "dual strobe no access", 32'(s_ce[1]), 1);
        chk("R8", "dual strobe flagged", 32'(o_err[1]), 1);

        // R7: overlapped reads on lane 2
        tick();
        drv(2, 1'b1, 1'b0, 6'd1, '0);
        tick(); quiet();
        chk("R7", "first count", 32'(o_cnt[2]), 2);
        tick();
        drv(2, 1'b1, 1'b0, 6'd7, '0);
        chk("R7", "window count", 32'(o_cnt[2]), 1);
        tick(); quiet();
        chk("R7", "older completes", 32'(o_cnt[2]), 0);
        chk("R7", "older data", o_rd[2], exp_mem[2][1]);
        tick();
        chk("R7", "newer count shown", 32'(o_cnt[2]), 1);
        tick();
        chk("R7", "newer completes", 32'(o_cnt[2]), 0);
        chk("R7", "newer data", o_rd[2], v7);

        // R8: reset clears the flag
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
        for (int l = 0; l < NL; l++) chk("R8", "reset clears error", 32'(o_err[l]), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule